// File: doc/BRIEF.md
# Measurement Mode Selector

This block chooses which of four measurement modes a meter front end is in (voltage, current, two-wire resistance, four-wire resistance) and drives the five analog switch enables that configure the input path for that mode. Each mode can be requested from a front-panel push button or from a remote request line. A separate enable controls each of the two sources. The button and remote requests for the same mode are ORed into one combined request line per mode.

A new request is detected on the rising edge of the OR of all combined request lines. On that event the whole request vector is loaded into a one-hot mode register in one step. If more than one line is active at that moment, the lowest-numbered mode is kept. The selected mode then stays active until the next event or a reset. The switch enables are decoded from the mode register and registered. In every resistance mode the voltmeter path stays closed, because the resistance measurement reads a voltage. The push buttons are synchronized and debounced in the system clock domain. The remote lines are taken as already synchronous.

Top module: `meas_mode_sel`

## Requirements
- R1: Bit positions of the request inputs and of `mode_onehot` are 0 = voltage, 1 = current, 2 = two-wire resistance, 3 = four-wire resistance. For each mode, an enabled button request or an enabled remote request is enough to select that mode.
- R2: A capture happens only when the OR of the combined requests rises. A request that is held, or a second request added while another is still held, causes no further capture and leaves the mode unchanged.
- R3: After a capture of a single request, exactly the requested bit of `mode_onehot` is 1. That value holds until the next capture.
- R4: When several combined requests are active at a capture, only the lowest-numbered one is stored, so `mode_onehot` never has more than one bit set.
- R5: While `rst` is high at a clock edge, `mode_onehot` clears to zero on that edge. All five switch outputs are 0 (open) one edge later.
- R6: In voltage mode only `sw_vm` is 1. In current mode only `sw_cm` is 1.
- R7: In two-wire mode `sw_vm`, `sw_2w` and `sw_fb2w` are 1. In four-wire mode `sw_vm` and `sw_fb4w` are 1. Every other switch is 0 in both modes.
- R8: A button level reaches the request logic only after it has been stable for DEBOUNCE_CYCLES clocks (default 16), following a two-flop synchronizer. A press of 8 clocks selects nothing.
- R9: With `local_en` low, buttons cannot cause a capture. With `remote_en` low, remote lines cannot cause a capture.
- R10: A remote request set up before clock edge k appears on `mode_onehot` after edge k. The switch outputs follow after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_in | input | 4 | Raw push-button levels, one per mode, asynchronous |
| remote_req | input | 4 | Remote request lines, one per mode, synchronous to clk |
| local_en | input | 1 | Allows button requests |
| remote_en | input | 1 | Allows remote requests |
| mode_onehot | output | 4 | Registered one-hot mode (all zero after reset) |
| sw_vm | output | 1 | Voltmeter path switch enable |
| sw_cm | output | 1 | Current meter path switch enable |
| sw_2w | output | 1 | Two-wire source switch enable |
| sw_fb2w | output | 1 | Two-wire feedback switch enable |
| sw_fb4w | output | 1 | Four-wire feedback switch enable |

## Verification
Each possible failure of the mode register shows at the ports within two clocks of a capture. A lost priority shows as two bits set on `mode_onehot`, and as a wrong switch set one clock later. A capture on a level instead of an edge shows as a mode change while a request is held. A wrong decode row shows only in the mode that uses it, so all four modes and several overlapping request patterns are applied. Debounce faults show only at the button thresholds, so presses shorter and longer than the debounce window are driven.

// File: rtl/meas_mode_pkg.sv
package meas_mode_pkg;
  localparam int NUM_MODES = 4;
  localparam int MODE_VOLT = 0;
  localparam int MODE_CURR = 1;
  localparam int MODE_RES2 = 2;
  localparam int MODE_RES4 = 3;

  typedef logic [NUM_MODES-1:0] mode_vec_t;

  typedef struct packed {
    logic vm;
    logic cm;
    logic w2;
    logic fb2w;
    logic fb4w;
  } sw_set_t;

  // isolate the lowest set bit
  function automatic mode_vec_t lowest_bit(input mode_vec_t v);
    return v & (~v + mode_vec_t'(1));
  endfunction
endpackage

// File: rtl/btn_debounce.sv
module btn_debounce #(
  parameter int SYNC_STAGES     = 2,
  parameter int DEBOUNCE_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_in,
  output logic level_out
);
  localparam int CW = $clog2(DEBOUNCE_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(DEBOUNCE_CYCLES - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;
  logic                   level_q;
  logic                   synced;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= raw_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], raw_in};
      end
    end
  endgenerate

  assign synced = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      level_q <= 1'b0;
    end else if (synced == level_q) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q   <= '0;
      level_q <= synced;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign level_out = level_q;

  // R8
  deb_follows_sync_chk: assert property (@(posedge clk) disable iff (rst)
    (level_q != $past(level_q)) |-> (level_q == $past(synced)));
endmodule

// File: rtl/mode_capture.sv
module mode_capture
  import meas_mode_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  mode_vec_t btn_req,
  input  mode_vec_t rem_req,
  input  logic      local_en,
  input  logic      remote_en,
  output mode_vec_t mode_q
);
  mode_vec_t combined;
  logic      any_req;
  logic      any_q;
  logic      capture;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_MODES; gi++) begin : g_or
      assign combined[gi] = (btn_req[gi] & local_en) | (rem_req[gi] & remote_en);
    end
  endgenerate

  assign any_req = |combined;
  assign capture = any_req & ~any_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      any_q  <= 1'b0;
      mode_q <= '0;
    end else begin
      any_q <= any_req;
      if (capture) mode_q <= lowest_bit(combined);
    end
  end

  // R4
  mode_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(mode_q));
  // R2
  hold_no_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (any_q && any_req) |=> $stable(mode_q));
  // R5
  reset_clear_chk: assert property (@(posedge clk) rst |=> (mode_q == '0));
endmodule

// File: rtl/switch_decode.sv
module switch_decode
  import meas_mode_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  mode_vec_t mode,
  output sw_set_t   sw_q
);
  sw_set_t sw_d;

  always_comb begin
    sw_d      = '0;
    sw_d.vm   = mode[MODE_VOLT] | mode[MODE_RES2] | mode[MODE_RES4];
    sw_d.cm   = mode[MODE_CURR];
    sw_d.w2   = mode[MODE_RES2];
    sw_d.fb2w = mode[MODE_RES2];
    sw_d.fb4w = mode[MODE_RES4];
  end

  always_ff @(posedge clk) begin
    if (rst) sw_q <= '0;
    else     sw_q <= sw_d;
  end

  // R6
  vm_cm_exclusive_chk: assert property (@(posedge clk) disable iff (rst) !(sw_q.vm && sw_q.cm));
  // R7
  res_needs_vm_chk: assert property (@(posedge clk) disable iff (rst)
    (sw_q.w2 || sw_q.fb4w) |-> sw_q.vm);
endmodule

// File: rtl/meas_mode_sel.sv
module meas_mode_sel
  import meas_mode_pkg::*;
#(
  parameter int SYNC_STAGES     = 2,
  parameter int DEBOUNCE_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] btn_in,
  input  logic [3:0] remote_req,
  input  logic       local_en,
  input  logic       remote_en,
  output logic [3:0] mode_onehot,
  output logic       sw_vm,
  output logic       sw_cm,
  output logic       sw_2w,
  output logic       sw_fb2w,
  output logic       sw_fb4w
);
  mode_vec_t btn_clean;
  mode_vec_t mode_q;
  sw_set_t   sw_q;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_MODES; gi++) begin : g_btn
      btn_debounce #(
        .SYNC_STAGES    (SYNC_STAGES),
        .DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)
      ) u_deb (
        .clk      (clk),
        .rst      (rst),
        .raw_in   (btn_in[gi]),
        .level_out(btn_clean[gi])
      );
    end
  endgenerate

  mode_capture u_cap (
    .clk      (clk),
    .rst      (rst),
    .btn_req  (btn_clean),
    .rem_req  (remote_req),
    .local_en (local_en),
    .remote_en(remote_en),
    .mode_q   (mode_q)
  );

  switch_decode u_dec (
    .clk (clk),
    .rst (rst),
    .mode(mode_q),
    .sw_q(sw_q)
  );

  assign mode_onehot = mode_q;
  assign sw_vm   = sw_q.vm;
  assign sw_cm   = sw_q.cm;
  assign sw_2w   = sw_q.w2;
  assign sw_fb2w = sw_q.fb2w;
  assign sw_fb4w = sw_q.fb4w;

  // R10
  switch_follows_mode_chk: assert property (@(posedge clk) disable iff (rst)
    $past(mode_onehot) == 4'b0001 |-> (sw_vm && !sw_cm && !sw_2w && !sw_fb4w));
endmodule

// File: tb/sim_meas_mode_sel.sv
module sim_meas_mode_sel;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  // request vector, expected mode, expected switches {vm,cm,2w,fb2w,fb4w}
  localparam logic [3:0] V_REQ  [NV] = '{4'b0001, 4'b0010, 4'b0100, 4'b1000,
                                         4'b0110, 4'b1100, 4'b1111, 4'b1010};
  localparam logic [3:0] V_MODE [NV] = '{4'b0001, 4'b0010, 4'b0100, 4'b1000,
                                         4'b0010, 4'b0100, 4'b0001, 4'b0010};
  localparam logic [4:0] V_SW   [NV] = '{5'b10000, 5'b01000, 5'b10110, 5'b10001,
                                         5'b01000, 5'b10110, 5'b10000, 5'b01000};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] btn_in = '0;
  logic [3:0] remote_req = '0;
  logic local_en = 1'b0;
  logic remote_en = 1'b0;
  logic [3:0] mode_onehot;
  logic sw_vm, sw_cm, sw_2w, sw_fb2w, sw_fb4w;
  int n_tests = 0;
  int n_fail = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  meas_mode_sel u0 (
    .clk(clk), .rst(rst), .btn_in(btn_in), .remote_req(remote_req),
    .local_en(local_en), .remote_en(remote_en), .mode_onehot(mode_onehot),
    .sw_vm(sw_vm), .sw_cm(sw_cm), .sw_2w(sw_2w), .sw_fb2w(sw_fb2w), .sw_fb4w(sw_fb4w)
  );

  function automatic logic [4:0] sws();
    return {sw_vm, sw_cm, sw_2w, sw_fb2w, sw_fb4w};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic remote_pulse(input logic [3:0] v);
    remote_req = v;
    cyc(3);
    remote_req = '0;
    cyc(2);
  endtask

  initial begin
    cyc(3);
    check("R5 reset mode", {4'b0, mode_onehot}, 8'h00);
    check("R5 reset switches", {3'b0, sws()}, 8'h00);
    rst = 1'b0;
    remote_en = 1'b1;
    local_en = 1'b1;
    cyc(2);

    // table walk: R1 R3 R4 R6 R7
    for (int k = 0; k < NV; k++) begin
      remote_req = V_REQ[k];
      cyc(3);
      check("R3/R4 table mode", {4'b0, mode_onehot}, {4'b0, V_MODE[k]});
      check("R6/R7 table switches", {3'b0, sws()}, {3'b0, V_SW[k]});
      remote_req = '0;
      cyc(2);
      check("R3 mode holds", {4'b0, mode_onehot}, {4'b0, V_MODE[k]});
    end

    // R10 latency: request driven before edge k
    remote_req = 4'b1000;
    cyc(1);
    check("R10 mode after one edge", {4'b0, mode_onehot}, 8'h08);
    check("R10 switches not yet", {3'b0, sws()}, {3'b0, 5'b01000});
    cyc(1);
    check("R10 switches after two edges", {3'b0, sws()}, {3'b0, 5'b10001});
    // R2: add a request while held: no capture
    remote_req = 4'b1001;
    cyc(3);
    check("R2 held request no recapture", {4'b0, mode_onehot}, 8'h08);
    remote_req = '0;
    cyc(2);

    // R9 remote disabled
    remote_en = 1'b0;
    remote_req = 4'b0001;
    cyc(3);
    check("R9 remote disabled", {4'b0, mode_onehot}, 8'h08);
    remote_req = '0;
    remote_en = 1'b1;
    cyc(2);

    // R8 short button press ignored
    btn_in = 4'b0010;
    cyc(8);
    btn_in = '0;
    cyc(30);
    check("R8 short press ignored", {4'b0, mode_onehot}, 8'h08);
    // R8/R1 long press selects via button
    btn_in = 4'b0010;
    cyc(30);
    check("R8 long press selects", {4'b0, mode_onehot}, 8'h02);
    check("R1 button switches", {3'b0, sws()}, {3'b0, 5'b01000});
    btn_in = '0;
    cyc(30);

    // R9 local disabled
    local_en = 1'b0;
    btn_in = 4'b0100;
    cyc(30);
    check("R9 local disabled", {4'b0, mode_onehot}, 8'h02);
    btn_in = '0;
    cyc(30);
    local_en = 1'b1;

    // R5 reset after a mode is set
    remote_pulse(4'b0100);
    check("R7 before reset", {3'b0, sws()}, {3'b0, 5'b10110});
    rst = 1'b1;
    cyc(1);
    check("R5 mode cleared", {4'b0, mode_onehot}, 8'h00);
    cyc(1);
    check("R5 switches open", {3'b0, sws()}, 8'h00);
    rst = 1'b0;
    cyc(2);
    done = 1'b1;
  end

  initial begin
    for (int t = 0; t < 20000; t++) begin
      @(negedge clk);
      if (done) break;
    end
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule